// File: doc/BRIEF.md
# Stereo Disparity Cross-View Validator

This block sits after disparity selection in a stereo pipeline. It takes the raw left-view and right-view disparity maps as two synchronised pixel streams, one pixel per view per clock. Each pixel carries an 8-bit disparity and a 4-bit segment label. For every pixel the block decides whether the other view confirms it. A left pixel at column x with disparity d is matched to the right pixel at column x-d. A right pixel at column x with disparity d is matched to the left pixel at column x+d. The pixel is confirmed only when the matched pixel reports the same disparity and carries the same segment label.

Each row is collected in full into one of two row banks. When the last column arrives, a sweep runs over that bank while the next row fills the other bank. The disparities leave the block unchanged; only a confirmation bit is added. Each output word is 9 bits: bit 8 is the confirmation flag and bits 7:0 hold the disparity. Downstream filling and voting stages use the flag to decide which pixels they may trust.

Top module: `disp_xcheck`

## Requirements
- R1: A pixel pair is accepted on every rising clock edge where `in_valid` is high. A row is complete after ROW_W accepted pairs, whether they arrive back to back or with idle cycles between them.
- R2: The output word for column 0 of a row appears one clock after the edge that accepts the row's last pixel. The remaining columns follow one per clock in increasing order, and `out_col` gives the column.
- R3: Bits 7:0 of `out_left` and `out_right` carry the input disparity of that column unchanged. Bit 8 is the confirmation flag.
- R4: A left pixel at column x with disparity d is confirmed only when all of these hold: x-d is at least 0, d is below MAX_DISP, the right pixel at column x-d of the same row has disparity d, and that right pixel has the same segment label.
- R5: A right pixel at column x with disparity d is confirmed only when all of these hold: x+d is below ROW_W, d is below MAX_DISP, the left pixel at column x+d has disparity d, and that left pixel has the same segment label.
- R6: When the two disparities agree but the segment labels differ, the pixel is not confirmed.
- R7: A left pixel whose disparity exceeds its column is not confirmed.
- R8: A right pixel whose column plus disparity reaches ROW_W or more is not confirmed.
- R9: A disparity of MAX_DISP or more is not confirmed in either view, even when the views agree. MAX_DISP-1 can still be confirmed.
- R10: A new row can be accepted while the previous row is being emitted, with no gap between rows, and the output of both rows stays correct.
- R11: While `rst_n` is low, `out_valid` is low. A partial row received before reset is discarded, and the first full row after reset is checked on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A pixel pair is present this cycle |
| in_ldisp | input | 8 | Left-view disparity |
| in_llab | input | 4 | Left-view segment label |
| in_rdisp | input | 8 | Right-view disparity |
| in_rlab | input | 4 | Right-view segment label |
| out_valid | output | 1 | Output words are present this cycle |
| out_col | output | $clog2(ROW_W) | Column of the output words |
| out_left | output | 9 | Left word: bit 8 is the flag, bits 7:0 the disparity |
| out_right | output | 9 | Right word: bit 8 is the flag, bits 7:0 the disparity |

## Verification
The bench aims at the row edges:
- A shifted scene with constant disparity should reject the first d left columns and the last d right columns. A design that got the subtraction or addition wrong would wrap the lookup around the row and confirm those columns.
- Segment labels that change under an agreeing disparity must clear the flag. A design that ignores the label would pass those pixels.
- Disparities just below and at MAX_DISP show an off-by-one in the range compare.

The bench also covers the ping-pong handover:
- Two rows streamed back to back would expose a bank that is swapped too late, which mixes data from the two rows.
- A reset in the middle of a row would expose a column counter that keeps running, which shifts every later column.

// File: rtl/disp_xcheck_pkg.sv
package disp_xcheck_pkg;
    localparam int DISP_W = 8;
    localparam int LAB_W  = 4;
    localparam int WORD_W = DISP_W + 1;

    typedef struct packed {
        logic [DISP_W-1:0] disp;
        logic [LAB_W-1:0]  lab;
    } pix_t;
endpackage

// File: rtl/disp_xcheck_store.sv
// Two row banks per view; one fills while the other is swept.
module disp_xcheck_store
    import disp_xcheck_pkg::*;
#(
    parameter int ROW_W = 1024,
    localparam int COL_W = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pix_t             wr_left,
    input  pix_t             wr_right,
    output logic             row_done,
    output logic             done_bank,
    input  logic             rd_bank,
    input  logic [COL_W-1:0] rd_col,
    input  logic [COL_W-1:0] lpeer_addr,
    input  logic [COL_W-1:0] rpeer_addr,
    output pix_t             own_left,
    output pix_t             own_right,
    output pix_t             lpeer,
    output pix_t             rpeer
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             bank;
    } wst_t;

    wst_t w_d, w_q;
    pix_t mem_l [2][ROW_W];
    pix_t mem_r [2][ROW_W];

    // R1: count accepted pairs; the bank flips after ROW_W of them
    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            if (w_q.col == COL_W'(ROW_W - 1)) begin
                w_d.col  = '0;
                w_d.bank = ~w_q.bank;
            end else begin
                w_d.col = w_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_l[w_q.bank][w_q.col] <= wr_left;
            mem_r[w_q.bank][w_q.col] <= wr_right;
        end
    end

    assign row_done  = wr_en && (w_q.col == COL_W'(ROW_W - 1));
    assign done_bank = w_q.bank;

    assign own_left  = mem_l[rd_bank][rd_col];
    assign own_right = mem_r[rd_bank][rd_col];
    assign lpeer     = mem_r[rd_bank][lpeer_addr];
    assign rpeer     = mem_l[rd_bank][rpeer_addr];
endmodule

// File: rtl/disp_xcheck_scan.sv
// Sweeps the completed bank one column per clock.
module disp_xcheck_scan #(
    parameter int ROW_W = 1024,
    localparam int COL_W = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bank,
    output logic             scan_valid,
    output logic             scan_bank,
    output logic [COL_W-1:0] scan_col
);
    typedef struct packed {
        logic             active;
        logic             bank;
        logic [COL_W-1:0] col;
    } sst_t;

    sst_t s_d, s_q;

    // R2: start at column 0 right after the last write, then step by one
    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.bank   = start_bank;
            s_d.col    = '0;
        end else if (s_q.active) begin
            if (s_q.col == COL_W'(ROW_W - 1)) begin
                s_d.active = 1'b0;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scan_valid = s_q.active;
    assign scan_bank  = s_q.bank;
    assign scan_col   = s_q.col;
endmodule

// File: rtl/disp_xcheck_side.sv
// Match test for one view; LOOK_RIGHT picks the lookup direction.
module disp_xcheck_side
    import disp_xcheck_pkg::*;
#(
    parameter int ROW_W      = 1024,
    parameter int MAX_DISP   = 64,
    parameter bit LOOK_RIGHT = 1'b0,
    localparam int COL_W = $clog2(ROW_W),
    localparam int AW    = ((COL_W > DISP_W) ? COL_W : DISP_W) + 2,
    localparam int DW1   = DISP_W + 1
) (
    input  logic [COL_W-1:0] col,
    input  pix_t             own,
    input  pix_t             peer,
    output logic [COL_W-1:0] peer_addr,
    output logic             ok
);
    logic          in_range;
    logic [AW-1:0] c_ext;
    logic [AW-1:0] d_ext;

    assign c_ext = AW'(col);
    assign d_ext = AW'(own.disp);

    generate
        if (LOOK_RIGHT) begin : g_plus
            // R8: right view looks at column x+d
            logic [AW-1:0] tgt;
            assign tgt       = c_ext + d_ext;
            assign in_range  = tgt < AW'(ROW_W);
            assign peer_addr = in_range ? COL_W'(tgt) : '0;
        end else begin : g_minus
            // R7: left view looks at column x-d
            assign in_range  = c_ext >= d_ext;
            assign peer_addr = in_range ? COL_W'(c_ext - d_ext) : '0;
        end
    endgenerate

    // R4 R5 R6 R9
    assign ok = in_range
             && ({1'b0, own.disp} < DW1'(MAX_DISP))
             && (peer.disp == own.disp)
             && (peer.lab  == own.lab);
endmodule

// File: rtl/disp_xcheck.sv
module disp_xcheck
    import disp_xcheck_pkg::*;
#(
    parameter int ROW_W    = 1024,
    parameter int MAX_DISP = 64,
    localparam int COL_W = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_ldisp,
    input  logic [3:0]       in_llab,
    input  logic [7:0]       in_rdisp,
    input  logic [3:0]       in_rlab,
    output logic             out_valid,
    output logic [COL_W-1:0] out_col,
    output logic [8:0]       out_left,
    output logic [8:0]       out_right
);
    typedef struct packed {
        logic              vld;
        logic [COL_W-1:0]  col;
        logic [WORD_W-1:0] lw;
        logic [WORD_W-1:0] rw;
    } ost_t;

    pix_t             wl, wr, own_l, own_r, peer_l, peer_r;
    logic             row_done, done_bank;
    logic             scan_valid, scan_bank;
    logic [COL_W-1:0] scan_col, laddr, raddr;
    logic             ok_l, ok_r;
    ost_t             o_d, o_q;

    assign wl = {in_ldisp, in_llab};
    assign wr = {in_rdisp, in_rlab};

    disp_xcheck_store #(.ROW_W(ROW_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (in_valid),
        .wr_left    (wl),
        .wr_right   (wr),
        .row_done   (row_done),
        .done_bank  (done_bank),
        .rd_bank    (scan_bank),
        .rd_col     (scan_col),
        .lpeer_addr (laddr),
        .rpeer_addr (raddr),
        .own_left   (own_l),
        .own_right  (own_r),
        .lpeer      (peer_l),
        .rpeer      (peer_r)
    );

    disp_xcheck_scan #(.ROW_W(ROW_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (row_done),
        .start_bank (done_bank),
        .scan_valid (scan_valid),
        .scan_bank  (scan_bank),
        .scan_col   (scan_col)
    );

    disp_xcheck_side #(.ROW_W(ROW_W), .MAX_DISP(MAX_DISP), .LOOK_RIGHT(1'b0)) u_left (
        .col       (scan_col),
        .own       (own_l),
        .peer      (peer_l),
        .peer_addr (laddr),
        .ok        (ok_l)
    );

    disp_xcheck_side #(.ROW_W(ROW_W), .MAX_DISP(MAX_DISP), .LOOK_RIGHT(1'b1)) u_right (
        .col       (scan_col),
        .own       (own_r),
        .peer      (peer_r),
        .peer_addr (raddr),
        .ok        (ok_r)
    );

    // R3: disparity passes through, flag in bit 8
    always_comb begin
        o_d     = o_q;
        o_d.vld = scan_valid;
        o_d.col = scan_col;
        o_d.lw  = {ok_l, own_l.disp};
        o_d.rw  = {ok_r, own_r.disp};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;   // R11
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_col   = o_q.col;
    assign out_left  = o_q.lw;
    assign out_right = o_q.rw;
endmodule

// File: rtl/disp_xcheck_chk.sv
module disp_xcheck_chk #(
    parameter int ROW_W    = 1024,
    parameter int MAX_DISP = 64,
    localparam int COL_W = $clog2(ROW_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic [COL_W-1:0] out_col,
    input logic [8:0]       out_left,
    input logic [8:0]       out_right
);
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_left[7:0]) > int'(out_col))) |-> !out_left[8]) else $error("left bound"); // R7

    AST_RIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_col) + int'(out_right[7:0]) >= ROW_W)) |-> !out_right[8]) else $error("right bound"); // R8

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_left[7:0]) >= MAX_DISP)) |-> !out_left[8]) else $error("left range"); // R9

    AST_RIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_right[7:0]) >= MAX_DISP)) |-> !out_right[8]) else $error("right range"); // R9

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(out_col) < ROW_W - 1)) |=> (out_valid && (out_col == $past(out_col) + 1'b1))) else $error("column step"); // R2

    AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> (out_col == '0)) else $error("row start"); // R2
endmodule

bind disp_xcheck disp_xcheck_chk #(.ROW_W(ROW_W), .MAX_DISP(MAX_DISP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_col   (out_col),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/disp_xcheck_test.sv
`timescale 1ns/1ps
module disp_xcheck_test;
    localparam int W    = 16;
    localparam int MAXD = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_ldisp = '0, in_rdisp = '0;
    logic [3:0] in_llab = '0, in_rlab = '0;
    logic       out_valid;
    logic [3:0] out_col;
    logic [8:0] out_left, out_right;

    always #2.5 clk = ~clk;

    disp_xcheck #(.ROW_W(W), .MAX_DISP(MAXD)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_ldisp(in_ldisp), .in_llab(in_llab),
        .in_rdisp(in_rdisp), .in_rlab(in_rlab),
        .out_valid(out_valid), .out_col(out_col),
        .out_left(out_left), .out_right(out_right)
    );

    int ld[W], ll[W], rd[W], rl[W];
    logic [8:0] exp_l[4*W], exp_r[4*W];
    string exp_tag[4];
    int rows_in = 0, rows_out = 0, mon_x = 0;
    bit mon_en = 1'b0;
    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    task automatic check_eq(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    // Monitor: compare every output column against the reference
    always @(negedge clk) begin : mon
        int s;
        if (mon_en && out_valid) begin
            s = rows_out % 4;
            if (rows_out >= rows_in) begin
                check_eq("R2", "unexpected output", 1, 0);
            end else begin
                check_eq("R2", "column order", int'(out_col), mon_x);
                check_eq(exp_tag[s], "left word", int'(out_left), int'(exp_l[s*W+mon_x]));
                check_eq(exp_tag[s], "right word", int'(out_right), int'(exp_r[s*W+mon_x]));
            end
            mon_x++;
            if (mon_x == W) begin
                mon_x = 0;
                rows_out++;
            end
        end
    end

    task automatic feed(string tag, int gap, bit keep);
        int s = rows_in % 4;
        for (int x = 0; x < W; x++) begin
            bit okl = 1'b0, okr = 1'b0;
            if (x >= ld[x] && ld[x] < MAXD)
                okl = (rd[x-ld[x]] == ld[x]) && (rl[x-ld[x]] == ll[x]);
            if (x + rd[x] < W && rd[x] < MAXD)
                okr = (ld[x+rd[x]] == rd[x]) && (ll[x+rd[x]] == rl[x]);
            exp_l[s*W+x] = {okl, 8'(ld[x])};
            exp_r[s*W+x] = {okr, 8'(rd[x])};
        end
        exp_tag[s] = tag;
        rows_in++;
        for (int x = 0; x < W; x++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_ldisp = 8'(ld[x]); in_llab = 4'(ll[x]);
            in_rdisp = 8'(rd[x]); in_rlab = 4'(rl[x]);
        end
        if (!keep) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (rows_out < rows_in && guard < 10*W) begin
            @(negedge clk);
            guard++;
        end
        check_eq("R2", "rows emitted", rows_out, rows_in);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        mon_en = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11", "out_valid in reset", int'(out_valid), 0);
        rows_in = 0; rows_out = 0; mon_x = 0;
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    task automatic fill_const(int d, int lab);
        for (int x = 0; x < W; x++) begin
            ld[x] = d; rd[x] = d; ll[x] = lab; rl[x] = lab;
        end
    endtask

    // R2 R3 R4 R5: zero disparity, equal labels; first output timing
    task automatic t_identity();
        for (int x = 0; x < W; x++) begin
            ld[x] = 0; rd[x] = 0; ll[x] = x % 16; rl[x] = x % 16;
        end
        feed("R3", 0, 1'b0);
        check_eq("R2", "no output one cycle early", int'(out_valid), 0);
        @(negedge clk);
        check_eq("R2", "first output valid", int'(out_valid), 1);
        check_eq("R2", "first output column", int'(out_col), 0);
        drain();
    endtask

    // R7 R8: constant shift, edges fall outside the row
    task automatic t_shift();
        fill_const(3, 5);
        feed("R7", 0, 1'b0);
        drain();
        fill_const(200, 2);
        feed("R8", 0, 1'b0);
        drain();
    endtask

    // R6: disparities agree, labels differ on columns 4..7 of the right view
    task automatic t_labels();
        fill_const(3, 5);
        for (int x = 4; x < 8; x++) rl[x] = 9;
        feed("R6", 0, 1'b0);
        drain();
    endtask

    // R9: MAX_DISP-1 still confirmed, MAX_DISP rejected
    task automatic t_range();
        fill_const(MAXD - 1, 1);
        feed("R9", 0, 1'b0);
        drain();
        fill_const(MAXD, 1);
        feed("R9", 0, 1'b0);
        drain();
    endtask

    task automatic fill_rand();
        for (int x = 0; x < W; x++) begin
            ld[x] = rnd() % 3; ll[x] = rnd() % 2;
            rd[x] = rnd() % 3; rl[x] = rnd() % 2;
        end
    endtask

    // R4 R5 R10: random rows streamed without any gap
    task automatic t_b2b();
        fill_rand();
        feed("R4", 0, 1'b1);
        fill_rand();
        feed("R10", 0, 1'b1);
        fill_rand();
        feed("R5", 0, 1'b0);
        drain();
    endtask

    // R1: idle cycles between pixels
    task automatic t_gaps();
        fill_rand();
        feed("R1", 2, 1'b0);
        drain();
    endtask

    // R11: partial row then reset
    task automatic t_partial();
        fill_const(1, 3);
        for (int x = 0; x < 7; x++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_ldisp = 8'd7; in_llab = 4'd1; in_rdisp = 8'd7; in_rlab = 4'd1;
        end
        do_reset();
        fill_rand();
        feed("R11", 0, 1'b0);
        drain();
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        t_identity();
        t_shift();
        t_labels();
        t_range();
        t_b2b();
        t_gaps();
        t_partial();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule